// File: doc/BRIEF.md
# SPI Slave Endpoint with Buffered Local Access

This block is the target side of an SPI link. An external controller drives the serial clock, the select line (active low) and the incoming data line; the block answers on its outgoing data line, which is only enabled while the select is active. All four clock idle-level/phase combinations are supported, frames are 8 or 16 bits long, and bits travel either most-significant or least-significant first. The mode, width and bit order are taken at the falling edge of the select and held for the whole frame.

The serial inputs are brought into the system clock domain through two-stage synchronizers, and serial clock edges are found there by comparing successive samples. For this to work, the system clock must run at least four times faster than the serial clock. On the local side sits a single-word transmit holding register and a single-word receive holding register. Flags report an empty transmit register, a full receive register, a frame in progress, and an overrun.

One frame is exchanged per select assertion. If the select rises before the frame is complete, the partial frame is discarded. If no word has been written when a frame starts, zeros are sent instead.

Top module: `spi_slave_buf`

## Requirements
- R1: After reset, `txe_o`=1, `rxne_o`=0, `ovr_o`=0, `busy_o`=0 and `miso_oe_o`=0.
- R2: With `cfg_cpha_i`=0, the first outgoing bit is driven after the select falls and before the first clock edge. Incoming bits are captured on leading edges, where the leading edge is the one leaving the idle level set by `cfg_cpol_i`. A round trip works for both idle levels.
- R3: With `cfg_cpha_i`=1, the outgoing line changes on leading edges and incoming bits are captured on trailing edges. A round trip works for both idle levels.
- R4: `cfg_wide_i`=0 selects 8-bit frames. In this mode bits [7:0] of the transmit word are sent and `rd_data_o[15:8]` reads as zero. `cfg_wide_i`=1 selects 16-bit frames that use the full word.
- R5: `cfg_lsb_first_i`=0 sends and receives the top bit of the frame first (bit 7 or bit 15). `cfg_lsb_first_i`=1 sends and receives bit 0 first.
- R6: `rxne_o` sets when a complete frame has been received. It stays set until a cycle with `rd_en_i`=1, after which it is 0.
- R7: A write (`wr_en_i`=1) clears `txe_o` in the next cycle. `txe_o` sets again when the written word is moved into the shifter at the start of a frame.
- R8: A frame that completes while `rxne_o` is set raises `ovr_o` and is dropped, so `rd_data_o` keeps the older word. `ovr_o` stays set until a read clears it.
- R9: A frame that starts while `txe_o`=1 sends all zeros.
- R10: If the select rises before the last bit is captured, the received bits are dropped and `rxne_o` is unchanged. The next frame is received correctly from its first bit.
- R11: Clock edges after the last bit of a frame, while the select is still low, have no effect. They start no new frame and cause no overrun.
- R12: `miso_oe_o` is 1 while the synchronized select is active and 0 otherwise. `busy_o` is 1 only while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cpol_i | input | 1 | Idle level of the serial clock |
| cfg_cpha_i | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| cfg_wide_i | input | 1 | 0: 8-bit frame; 1: 16-bit frame |
| cfg_lsb_first_i | input | 1 | 1: bit 0 travels first |
| sck_i | input | 1 | Serial clock from the controller |
| ss_ni | input | 1 | Select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for miso_o |
| wr_en_i | input | 1 | Write strobe for the transmit word |
| wr_data_i | input | 16 | Transmit word |
| rd_en_i | input | 1 | Read strobe; clears receive-full and overrun |
| rd_data_o | output | 16 | Received word |
| txe_o | output | 1 | Transmit register empty |
| rxne_o | output | 1 | Receive register holds unread data |
| ovr_o | output | 1 | A frame was dropped because of an unread word |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench runs a round trip in each of the four clock idle-level/phase combinations with 8-bit MSB-first frames. It uses asymmetric bit patterns, so a wrong capture edge or a one-bit output skew shows up as a shifted value. A 16-bit LSB-first frame and an 8-bit frame with a non-zero upper transmit byte tell apart the bit order and the width handling. The bench also covers flag behaviour:
- back-to-back frames without a read show whether the overrun drops the new word;
- a frame with no written word shows whether zeros are sent;
- a frame cut short by the select, then a normal frame, shows whether partial bits leak into the next frame;
- a frame with surplus clocks shows whether the block starts a second frame or reports an overrun.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    // Per-frame configuration, latched when the select falls.
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic wide;
        logic lsb;
    } frame_cfg_t;

endpackage

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic ss_ni,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic mosi_o,
    output logic ss_act_o,
    output logic ss_start_o
);
    // Index STAGES-1 is the synchronized value, index STAGES the previous one.
    localparam int CL = STAGES + 1;

    typedef struct packed {
        logic [CL-1:0] sck;
        logic [CL-1:0] mosi;
        logic [CL-1:0] ss;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sck  = {q.sck[CL-2:0], sck_i};
        d.mosi = {q.mosi[CL-2:0], mosi_i};
        d.ss   = {q.ss[CL-2:0], ss_ni};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.sck  <= '0;
            q.mosi <= '0;
            q.ss   <= '1;
        end else begin
            q <= d;
        end
    end

    assign sck_rise_o = q.sck[STAGES-1] & ~q.sck[STAGES];
    assign sck_fall_o = ~q.sck[STAGES-1] & q.sck[STAGES];
    assign mosi_o     = q.mosi[STAGES-1];
    assign ss_act_o   = ~q.ss[STAGES-1];
    assign ss_start_o = ~q.ss[STAGES-1] & q.ss[STAGES];

endmodule

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter
    import spi_slave_pkg::*;
#(
    parameter int DW = 16,
    parameter int NW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  frame_cfg_t    cfg_i,
    input  logic          sck_rise_i,
    input  logic          sck_fall_i,
    input  logic          mosi_i,
    input  logic          ss_act_i,
    input  logic          ss_start_i,
    input  logic [DW-1:0] tx_word_i,
    output logic          load_o,
    output logic          done_o,
    output logic [DW-1:0] rx_word_o,
    output logic          busy_o,
    output logic          miso_o,
    output logic          miso_oe_o
);
    localparam int CW = $clog2(DW + 1);
    localparam int IW = $clog2(DW);

    typedef struct packed {
        logic          active;
        logic          oe;
        frame_cfg_t    cfg;
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
        logic [CW-1:0] in_cnt;
        logic [CW-1:0] out_cnt;
        logic          miso;
    } shf_t;

    shf_t q, d;

    function automatic logic [IW-1:0] bit_idx(input logic [CW-1:0] c,
                                              input logic [CW-1:0] len,
                                              input logic          lsb);
        return lsb ? IW'(c) : IW'(len - CW'(1) - c);
    endfunction

    logic [CW-1:0] len_q;
    logic [CW-1:0] len_start;
    logic          lead, trail, out_ev, cap_ev;

    always_comb begin
        len_q     = q.cfg.wide ? CW'(DW) : CW'(NW);
        len_start = cfg_i.wide ? CW'(DW) : CW'(NW);
        lead      = q.cfg.cpol ? sck_fall_i : sck_rise_i;
        trail     = q.cfg.cpol ? sck_rise_i : sck_fall_i;
        out_ev    = q.cfg.cpha ? lead  : trail;
        cap_ev    = q.cfg.cpha ? trail : lead;

        d      = q;
        d.oe   = ss_act_i;
        load_o = 1'b0;
        done_o = 1'b0;

        if (ss_start_i) begin
            load_o    = 1'b1;
            d.active  = 1'b1;
            d.cfg     = cfg_i;
            d.tx      = tx_word_i;
            d.rx      = '0;
            d.in_cnt  = '0;
            if (!cfg_i.cpha) begin
                d.miso    = tx_word_i[bit_idx('0, len_start, cfg_i.lsb)];
                d.out_cnt = CW'(1);
            end else begin
                d.miso    = 1'b0;
                d.out_cnt = '0;
            end
        end else if (!ss_act_i) begin
            d.active = 1'b0;
        end else if (q.active) begin
            if (out_ev && (q.out_cnt < len_q)) begin
                d.miso    = q.tx[bit_idx(q.out_cnt, len_q, q.cfg.lsb)];
                d.out_cnt = q.out_cnt + CW'(1);
            end
            if (cap_ev) begin
                d.rx[bit_idx(q.in_cnt, len_q, q.cfg.lsb)] = mosi_i;
                if (q.in_cnt == len_q - CW'(1)) begin
                    done_o   = 1'b1;
                    d.active = 1'b0;
                end else begin
                    d.in_cnt = q.in_cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_word_o = d.rx;
    assign busy_o    = q.active;
    assign miso_o    = q.miso;
    assign miso_oe_o = q.oe;

endmodule

// File: rtl/spi_slave_regs.sv
module spi_slave_regs #(
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    input  logic          load_i,
    input  logic          done_i,
    input  logic [DW-1:0] rx_word_i,
    output logic [DW-1:0] tx_word_o,
    output logic [DW-1:0] rd_data_o,
    output logic          txe_o,
    output logic          rxne_o,
    output logic          ovr_o
);
    typedef struct packed {
        logic [DW-1:0] tx_buf;
        logic [DW-1:0] rx_buf;
        logic          txe;
        logic          rxne;
        logic          ovr;
    } reg_t;

    reg_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.txe = 1'b1;
        end
        if (wr_en_i) begin
            d.tx_buf = wr_data_i;
            d.txe    = 1'b0;
        end
        if (rd_en_i) begin
            d.rxne = 1'b0;
            d.ovr  = 1'b0;
        end
        if (done_i) begin
            if (q.rxne && !rd_en_i) begin
                d.ovr = 1'b1;
            end else begin
                d.rx_buf = rx_word_i;
                d.rxne   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q     <= '0;
            q.txe <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_word_o = q.txe ? '0 : q.tx_buf;
    assign rd_data_o = q.rx_buf;
    assign txe_o     = q.txe;
    assign rxne_o    = q.rxne;
    assign ovr_o     = q.ovr;

endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf
    import spi_slave_pkg::*;
#(
    parameter int DW          = 16,
    parameter int NW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_cpol_i,
    input  logic          cfg_cpha_i,
    input  logic          cfg_wide_i,
    input  logic          cfg_lsb_first_i,
    input  logic          sck_i,
    input  logic          ss_ni,
    input  logic          mosi_i,
    output logic          miso_o,
    output logic          miso_oe_o,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    output logic [DW-1:0] rd_data_o,
    output logic          txe_o,
    output logic          rxne_o,
    output logic          ovr_o,
    output logic          busy_o
);
    frame_cfg_t    cfg;
    logic          sck_rise, sck_fall, mosi_s, ss_act, ss_start;
    logic          load, done;
    logic [DW-1:0] tx_word, rx_word;

    assign cfg = '{cpol: cfg_cpol_i, cpha: cfg_cpha_i,
                   wide: cfg_wide_i, lsb: cfg_lsb_first_i};

    spi_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sck_i      (sck_i),
        .mosi_i     (mosi_i),
        .ss_ni      (ss_ni),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .mosi_o     (mosi_s),
        .ss_act_o   (ss_act),
        .ss_start_o (ss_start)
    );

    spi_slave_shifter #(.DW(DW), .NW(NW)) u_shf (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_i      (cfg),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .mosi_i     (mosi_s),
        .ss_act_i   (ss_act),
        .ss_start_i (ss_start),
        .tx_word_i  (tx_word),
        .load_o     (load),
        .done_o     (done),
        .rx_word_o  (rx_word),
        .busy_o     (busy_o),
        .miso_o     (miso_o),
        .miso_oe_o  (miso_oe_o)
    );

    spi_slave_regs #(.DW(DW)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .load_i    (load),
        .done_i    (done),
        .rx_word_i (rx_word),
        .tx_word_o (tx_word),
        .rd_data_o (rd_data_o),
        .txe_o     (txe_o),
        .rxne_o    (rxne_o),
        .ovr_o     (ovr_o)
    );

endmodule

// File: rtl/spi_slave_buf_chk.sv
module spi_slave_buf_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic wr_en_i,
    input logic rd_en_i,
    input logic txe_o,
    input logic rxne_o,
    input logic ovr_o,
    input logic busy_o,
    input logic miso_oe_o
);
    // R7
    txe_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> !txe_o);

    // R6
    rxne_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rxne_o && !rd_en_i |=> rxne_o);

    // R6
    rxne_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i && !busy_o |=> !rxne_o);

    // R8
    ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_o && !rd_en_i |=> ovr_o);

    // R8
    ovr_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovr_o) |-> rxne_o);

    // R12
    busy_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> miso_oe_o);

endmodule

bind spi_slave_buf spi_slave_buf_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .txe_o     (txe_o),
    .rxne_o    (rxne_o),
    .ovr_o     (ovr_o),
    .busy_o    (busy_o),
    .miso_oe_o (miso_oe_o)
);

// File: tb/spi_slave_buf_tb.sv
module spi_slave_buf_tb;
    localparam int H = 8; // system cycles per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpol = 1'b0, cpha = 1'b0, wide = 1'b0, lsb = 1'b0;
    logic        sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        txe, rxne, ovr, busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_slave_buf u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .cfg_cpol_i      (cpol),
        .cfg_cpha_i      (cpha),
        .cfg_wide_i      (wide),
        .cfg_lsb_first_i (lsb),
        .sck_i           (sck),
        .ss_ni           (ss_n),
        .mosi_i          (mosi),
        .miso_o          (miso),
        .miso_oe_o       (miso_oe),
        .wr_en_i         (wr_en),
        .wr_data_i       (wr_data),
        .rd_en_i         (rd_en),
        .rd_data_o       (rd_data),
        .txe_o           (txe),
        .rxne_o          (rxne),
        .ovr_o           (ovr),
        .busy_o          (busy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic local_write(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic local_read();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Controller model: nclk clock pulses, frame of nbits, returns received bits.
    task automatic xfer(input logic [15:0] mo, input int nbits, input int nclk,
                        output logic [15:0] mi);
        mi = '0;
        sck = cpol;
        wait_cyc(2);
        ss_n = 1'b0;
        if (!cpha) mosi = lsb ? mo[0] : mo[nbits-1];
        for (int i = 0; i < nclk; i++) begin
            int b_in  = lsb ? i : nbits - 1 - i;
            int b_nxt = lsb ? i + 1 : nbits - 2 - i;
            wait_cyc(H);
            if (cpha) begin
                mosi = (i < nbits) ? mo[b_in] : 1'b0;
            end else if (i < nbits) begin
                mi[b_in] = miso;
            end
            sck = ~cpol;
            wait_cyc(H);
            if (cpha && i < nbits) mi[b_in] = miso;
            sck = cpol;
            if (!cpha) mosi = (i + 1 < nbits) ? mo[b_nxt] : 1'b0;
        end
        wait_cyc(H);
        ss_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic set_cfg(input logic p, input logic h, input logic w, input logic l);
        cpol = p; cpha = h; wide = w; lsb = l;
        wait_cyc(2);
    endtask

    task automatic t_reset();
        chk("R1 txe", {15'd0, txe}, 16'd1);
        chk("R1 rxne", {15'd0, rxne}, 16'd0);
        chk("R1 ovr", {15'd0, ovr}, 16'd0);
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 miso_oe", {15'd0, miso_oe}, 16'd0);
    endtask

    task automatic t_round(input string req, input logic p, input logic h,
                           input logic w, input logic l,
                           input logic [15:0] tx, input logic [15:0] mo);
        logic [15:0] mi;
        logic [15:0] mask;
        int          nb;
        mask = w ? 16'hFFFF : 16'h00FF;
        nb   = w ? 16 : 8;
        set_cfg(p, h, w, l);
        local_write(tx);
        chk({req, " R7 txe after write"}, {15'd0, txe}, 16'd0);
        xfer(mo, nb, nb, mi);
        chk({req, " R4 R5 slave->ctrl"}, mi, tx & mask);
        chk({req, " R4 R5 ctrl->slave"}, rd_data, mo & mask);
        chk({req, " R6 rxne set"}, {15'd0, rxne}, 16'd1);
        chk({req, " R7 txe after load"}, {15'd0, txe}, 16'd1);
        local_read();
        chk({req, " R6 rxne cleared"}, {15'd0, rxne}, 16'd0);
    endtask

    task automatic t_overrun_underrun();
        logic [15:0] mi;
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        xfer(16'h0011, 8, 8, mi);
        chk("R9 zeros sent when empty", mi, 16'h0000);
        xfer(16'h0022, 8, 8, mi);
        chk("R8 ovr set", {15'd0, ovr}, 16'd1);
        chk("R8 old word kept", rd_data, 16'h0011);
        chk("R8 rxne still set", {15'd0, rxne}, 16'd1);
        local_read();
        chk("R8 ovr cleared by read", {15'd0, ovr}, 16'd0);
        chk("R6 rxne cleared by read", {15'd0, rxne}, 16'd0);
    endtask

    task automatic t_abort();
        logic [15:0] mi;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        ss_n = 1'b0;
        wait_cyc(5);
        chk("R12 oe while selected", {15'd0, miso_oe}, 16'd1);
        chk("R12 busy while selected", {15'd0, busy}, 16'd1);
        ss_n = 1'b1;
        wait_cyc(5);
        chk("R12 oe released", {15'd0, miso_oe}, 16'd0);
        chk("R12 busy released", {15'd0, busy}, 16'd0);
        xfer(16'h00FF, 8, 3, mi);
        chk("R10 partial frame dropped", {15'd0, rxne}, 16'd0);
        local_write(16'h0096);
        xfer(16'h0069, 8, 8, mi);
        chk("R10 next frame data", rd_data, 16'h0069);
        chk("R10 next frame tx", mi, 16'h0096);
        local_read();
    endtask

    task automatic t_extra_clocks();
        logic [15:0] mi;
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        local_write(16'h00C3);
        xfer(16'h00B4, 8, 12, mi);
        chk("R11 data after surplus clocks", rd_data, 16'h00B4);
        chk("R11 tx after surplus clocks", mi, 16'h00C3);
        chk("R11 no overrun", {15'd0, ovr}, 16'd0);
        chk("R11 rxne", {15'd0, rxne}, 16'd1);
        chk("R11 txe", {15'd0, txe}, 16'd1);
        local_read();
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_round("R2 mode0", 1'b0, 1'b0, 1'b0, 1'b0, 16'h00A6, 16'h003C);
        t_round("R2 mode2", 1'b1, 1'b0, 1'b0, 1'b0, 16'h0071, 16'h00D2);
        t_round("R3 mode1", 1'b0, 1'b1, 1'b0, 1'b0, 16'h004B, 16'h00E1);
        t_round("R3 mode3", 1'b1, 1'b1, 1'b0, 1'b0, 16'h0019, 16'h008E);
        t_round("R5 wide lsb", 1'b0, 1'b0, 1'b1, 1'b1, 16'h1234, 16'hBEEF);
        t_round("R5 wide msb", 1'b1, 1'b1, 1'b1, 1'b0, 16'hC001, 16'h0F5A);
        t_round("R4 narrow upper", 1'b0, 1'b1, 1'b0, 1'b1, 16'hFF5A, 16'h00A3);
        t_overrun_underrun();
        t_abort();
        t_extra_clocks();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule